// File: doc/BRIEF.md
# Platform Sleep/Wake Power Sequencer

This block orders the active-low sleep, status and reset outputs of a platform as the rails come up, as the platform enters a suspend state and as it wakes again. It watches a standby-rail good input, a resume-reset release, a main-rail good input, a power-OK, a wake event, a stop-grant indication and a sleep request with its level (shallow or deep). It drives a shallow-sleep strobe, a deep-sleep strobe, a suspend-status, a bus reset, a CPU sleep and a stop-clock output. All six outputs are active low.

Every delay is counted in one of three timebases: slow real-time ticks, bus clocks, or microsecond ticks. The slow ticks and the microsecond ticks arrive as one-cycle enable pulses on the single bus-rate clock. A dropped standby rail sends the block back to its all-asserted state. A wake that arrives part-way through suspend entry is kept until entry has finished.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `susp_good` is low, all six outputs are driven low from the next clock edge. They are also all low in reset, and they stay low while waiting for `rsm_rel`.
- R2: After `rsm_rel` is seen high with `susp_good` high, `slp_shallow_n`, `slp_deep_n` and `susp_stat_n` go high on the 2nd slow tick. `bus_rst_n`, `cpu_slp_n` and `stpclk_n` stay low.
- R3: Once the strobes are released, `cpu_slp_n` goes high within two clocks of `main_good` being high.
- R4: `bus_rst_n` goes high on the 1000th microsecond tick (parameter `RST_US`) after `pwr_ok` is seen high. With 1 µs ticks this is 1.0 ms, which lies inside the 0.9–1.1 ms window.
- R5: `stpclk_n` goes high exactly 2 bus clocks after `bus_rst_n` goes high.
- R6: When all outputs are high, a `sleep_req` pulse drives `stpclk_n` low on the next edge. `cpu_slp_n` then goes low exactly 8 bus clocks after the edge that samples `stop_grant` high.
- R7: `susp_stat_n` goes low on the 1st slow tick after `cpu_slp_n` goes low.
- R8: `bus_rst_n` goes low on the 3rd slow tick after `susp_stat_n` falls. `slp_shallow_n` then goes low on the 2nd slow tick after that.
- R9: If `sleep_deep` was high with `sleep_req`, `slp_deep_n` goes low on the 2nd slow tick after `slp_shallow_n` falls. Otherwise `slp_deep_n` stays high.
- R10: A wake from shallow sleep releases `slp_shallow_n` and `susp_stat_n` on the 3rd slow tick. A wake from deep sleep first releases `slp_deep_n` on the 3rd slow tick, then releases `slp_shallow_n` and `susp_stat_n` on the 3rd slow tick after that. Power-up then resumes at R3.
- R11: A `wake` pulse during suspend entry is held. The wake sequence then starts right after the sleep strobes reach their final level. A `wake` pulse while all outputs are high has no effect, and a later sleep stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| susp_good | input | 1 | Standby-rail power good |
| rsm_rel | input | 1 | Resume reset released (level) |
| main_good | input | 1 | Main-rail power good |
| pwr_ok | input | 1 | Power-OK |
| slow_tick | input | 1 | One-cycle slow real-time tick enable |
| us_tick | input | 1 | One-cycle microsecond tick enable |
| wake | input | 1 | Wake event pulse |
| stop_grant | input | 1 | Stop-grant indication pulse |
| sleep_req | input | 1 | Suspend request pulse |
| sleep_deep | input | 1 | Requested level, sampled with sleep_req: 1 deep, 0 shallow |
| slp_shallow_n | output | 1 | Shallow-sleep strobe, active low |
| slp_deep_n | output | 1 | Deep-sleep strobe, active low |
| susp_stat_n | output | 1 | Suspend status, active low |
| bus_rst_n | output | 1 | Bus reset, active low |
| cpu_slp_n | output | 1 | CPU sleep, active low |
| stpclk_n | output | 1 | Stop clock, active low |

## Verification
The assertions check the following orderings on every cycle:
- the all-asserted state that follows a standby-rail drop;
- that the bus reset is released only after the strobes and CPU sleep are high;
- that stop-clock is released only after the bus reset;
- that status falls only with CPU sleep low, the shallow strobe falls only with the bus reset low, and the deep strobe falls only after the shallow one;
- that on wake the deep strobe is never behind the shallow one;
- that a pending wake is only taken during entry.

The exact tick and clock counts of each step, the shallow versus deep choice, and the holding or ignoring of wake events can only be shown by the bench scenarios. Those scenarios count individual ticks and compare the outputs between them.

// File: rtl/pwr_seq_pkg.sv
// Package: shared state encoding and delay-channel indices for the sequencer.
// Assumes: one bus-rate clock domain; all outputs active low.
package pwr_seq_pkg;

    localparam int NUM_DLY  = 3;
    localparam int DLY_SLOW = 0;   // slow real-time tick channel
    localparam int DLY_BUS  = 1;   // bus clock channel
    localparam int DLY_US   = 2;   // microsecond tick channel

    typedef enum logic [4:0] {
        S_OFF,        // standby rail down or resume reset held
        S_RSM_DLY,    // counting slow ticks after resume release
        S_WAIT_MAIN,  // strobes released, waiting for main rail
        S_WAIT_PWROK, // CPU sleep released, waiting for power-OK
        S_RST_DLY,    // counting microseconds before bus reset release
        S_STP_DLY,    // counting bus clocks before stop-clock release
        S_ON,         // fully running
        S_WAIT_GNT,   // stop-clock asserted, waiting for stop-grant
        S_CPU_DLY,    // counting bus clocks before CPU sleep
        S_STAT_DLY,   // counting slow ticks before suspend status
        S_BRST_DLY,   // counting slow ticks before bus reset
        S_SHL_DLY,    // counting slow ticks before shallow strobe
        S_DEEP_DLY,   // counting slow ticks before deep strobe
        S_SLEEP,      // asleep, waiting for wake
        S_WDEEP_DLY,  // wake: counting before deep strobe release
        S_WSHL_DLY    // wake: counting before shallow strobe release
    } seq_state_e;

endpackage

// File: rtl/seq_delay.sv
// Module: seq_delay
// Loadable down-counter of tick enables. A start pulse loads the target, and
// done pulses combinationally in the cycle of the target-th tick after the
// load. Assumes target >= 1; start takes priority over an ongoing count.
module seq_delay #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start,
    input  logic [CW-1:0] target,
    input  logic          tick,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic          busy;

    assign done = busy && tick && (cnt == CW'(1));

    // Load on start, count down on each tick, stop after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= target;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy && tick) begin
            cnt <= cnt - CW'(1);
        end
    end

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (target != '0)); // R4

endmodule

// File: rtl/seq_wake_hold.sv
// Module: seq_wake_hold
// Holds a wake event that arrives during the suspend-entry window until the
// sequencer consumes it. Wakes outside the window are dropped.
module seq_wake_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wake,
    input  logic capture_en,
    input  logic consume,
    output logic pending
);
    // Set on a wake inside the window, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               pending <= 1'b0;
        else if (consume)                pending <= 1'b0;
        else if (wake && capture_en)     pending <= 1'b1;
    end

    AST_PEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(capture_en)); // R11

endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Main sequencing state machine. It issues start pulses and targets to the
// three delay channels on each transition and decodes the six active-low
// outputs from its state. Assumes the delay channels report done in the
// cycle of the final tick.
module seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int CW         = 10,
    parameter int RSM_TICKS  = 2,
    parameter int STAT_TICKS = 1,
    parameter int BRST_TICKS = 3,
    parameter int SHL_TICKS  = 2,
    parameter int DEEP_TICKS = 2,
    parameter int WAKE_TICKS = 3,
    parameter int CPU_CLKS   = 8,
    parameter int STP_CLKS   = 2,
    parameter int RST_US     = 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        susp_good,
    input  logic                        rsm_rel,
    input  logic                        main_good,
    input  logic                        pwr_ok,
    input  logic                        wake_any,
    input  logic                        sleep_req,
    input  logic                        sleep_deep,
    input  logic                        stop_grant,
    input  logic [NUM_DLY-1:0]          dly_done,
    output logic [NUM_DLY-1:0]          dly_start,
    output logic [NUM_DLY-1:0][CW-1:0]  dly_target,
    output logic                        entry_win,
    output logic                        wake_take,
    output logic                        slp_shallow_n,
    output logic                        slp_deep_n,
    output logic                        susp_stat_n,
    output logic                        bus_rst_n,
    output logic                        cpu_slp_n,
    output logic                        stpclk_n
);
    seq_state_e st, st_nx;
    logic       deep_lvl, deep_nx;

    // Next-state logic with delay-channel start requests.
    always_comb begin
        st_nx      = st;
        deep_nx    = deep_lvl;
        dly_start  = '0;
        dly_target = '0;
        if (!susp_good) begin
            st_nx = S_OFF;
        end else begin
            unique case (st)
                S_OFF: if (rsm_rel) begin
                    st_nx = S_RSM_DLY;
                    dly_start[DLY_SLOW]  = 1'b1;
                    dly_target[DLY_SLOW] = CW'(RSM_TICKS);
                end
                S_RSM_DLY:    if (dly_done[DLY_SLOW]) st_nx = S_WAIT_MAIN;
                S_WAIT_MAIN:  if (main_good) st_nx = S_WAIT_PWROK;
                S_WAIT_PWROK: if (pwr_ok) begin
                    st_nx = S_RST_DLY;
                    dly_start[DLY_US]  = 1'b1;
                    dly_target[DLY_US] = CW'(RST_US);
                end
                S_RST_DLY: if (dly_done[DLY_US]) begin
                    st_nx = S_STP_DLY;
                    dly_start[DLY_BUS]  = 1'b1;
                    dly_target[DLY_BUS] = CW'(STP_CLKS);
                end
                S_STP_DLY: if (dly_done[DLY_BUS]) st_nx = S_ON;
                S_ON: if (sleep_req) begin
                    st_nx   = S_WAIT_GNT;
                    deep_nx = sleep_deep;
                end
                S_WAIT_GNT: if (stop_grant) begin
                    st_nx = S_CPU_DLY;
                    dly_start[DLY_BUS]  = 1'b1;
                    dly_target[DLY_BUS] = CW'(CPU_CLKS);
                end
                S_CPU_DLY: if (dly_done[DLY_BUS]) begin
                    st_nx = S_STAT_DLY;
                    dly_start[DLY_SLOW]  = 1'b1;
                    dly_target[DLY_SLOW] = CW'(STAT_TICKS);
                end
                S_STAT_DLY: if (dly_done[DLY_SLOW]) begin
                    st_nx = S_BRST_DLY;
                    dly_start[DLY_SLOW]  = 1'b1;
                    dly_target[DLY_SLOW] = CW'(BRST_TICKS);
                end
                S_BRST_DLY: if (dly_done[DLY_SLOW]) begin
                    st_nx = S_SHL_DLY;
                    dly_start[DLY_SLOW]  = 1'b1;
                    dly_target[DLY_SLOW] = CW'(SHL_TICKS);
                end
                S_SHL_DLY: if (dly_done[DLY_SLOW]) begin
                    if (deep_lvl) begin
                        st_nx = S_DEEP_DLY;
                        dly_start[DLY_SLOW]  = 1'b1;
                        dly_target[DLY_SLOW] = CW'(DEEP_TICKS);
                    end else begin
                        st_nx = S_SLEEP;
                    end
                end
                S_DEEP_DLY: if (dly_done[DLY_SLOW]) st_nx = S_SLEEP;
                S_SLEEP: if (wake_any) begin
                    st_nx = deep_lvl ? S_WDEEP_DLY : S_WSHL_DLY;
                    dly_start[DLY_SLOW]  = 1'b1;
                    dly_target[DLY_SLOW] = CW'(WAKE_TICKS);
                end
                S_WDEEP_DLY: if (dly_done[DLY_SLOW]) begin
                    st_nx = S_WSHL_DLY;
                    dly_start[DLY_SLOW]  = 1'b1;
                    dly_target[DLY_SLOW] = CW'(WAKE_TICKS);
                end
                S_WSHL_DLY: if (dly_done[DLY_SLOW]) st_nx = S_WAIT_MAIN;
                default: st_nx = S_OFF;
            endcase
        end
    end

    // State and latched sleep level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_OFF;
            deep_lvl <= 1'b0;
        end else begin
            st       <= st_nx;
            deep_lvl <= deep_nx;
        end
    end

    assign entry_win = (st inside {S_WAIT_GNT, S_CPU_DLY, S_STAT_DLY,
                                   S_BRST_DLY, S_SHL_DLY, S_DEEP_DLY});
    assign wake_take = (st == S_SLEEP) && susp_good && wake_any;

    // Output decode per state (0 = asserted).
    always_comb begin
        {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111111;
        unique case (st)
            S_OFF, S_RSM_DLY:           {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b000000;
            S_WAIT_MAIN:                {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111000;
            S_WAIT_PWROK, S_RST_DLY:    {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111010;
            S_STP_DLY:                  {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111110;
            S_ON:                       {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111111;
            S_WAIT_GNT, S_CPU_DLY:      {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111110;
            S_STAT_DLY:                 {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b111100;
            S_BRST_DLY:                 {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b110100;
            S_SHL_DLY:                  {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b110000;
            S_DEEP_DLY:                 {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b010000;
            S_SLEEP:                    {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = {1'b0, !deep_lvl, 4'b0000};
            S_WDEEP_DLY:                {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b000000;
            S_WSHL_DLY:                 {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b010000;
            default:                    {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} = 6'b000000;
        endcase
    end

    AST_OFF_ALL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_good |=> ({slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n} == 6'b000000)); // R1
    AST_BUSRST_AFTER_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_n) |-> (slp_shallow_n && slp_deep_n && susp_stat_n && cpu_slp_n)); // R4
    AST_STPCLK_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stpclk_n) |-> (bus_rst_n && $past(bus_rst_n))); // R5
    AST_STAT_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(susp_stat_n) && $past(susp_good)) |-> !$past(cpu_slp_n)); // R7
    AST_SHALLOW_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(slp_shallow_n) && $past(susp_good)) |-> !$past(bus_rst_n)); // R8
    AST_DEEP_AFTER_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(slp_deep_n) && $past(susp_good)) |-> !$past(slp_shallow_n)); // R9
    AST_DEEP_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_shallow_n) |-> slp_deep_n); // R10

endmodule

// File: rtl/pwr_seq_ctrl.sv
// Module: pwr_seq_ctrl (top)
// Platform sleep/wake power sequencer. It ties the state machine to three
// tick-counting delay channels (slow ticks, bus clocks, microsecond ticks)
// and to the pending-wake holder. Assumes tick inputs are one-cycle pulses
// synchronous to clk. A low standby rail clears all state synchronously.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int RSM_TICKS  = 2,
    parameter int STAT_TICKS = 1,
    parameter int BRST_TICKS = 3,
    parameter int SHL_TICKS  = 2,
    parameter int DEEP_TICKS = 2,
    parameter int WAKE_TICKS = 3,
    parameter int CPU_CLKS   = 8,
    parameter int STP_CLKS   = 2,
    parameter int RST_US     = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_good,
    input  logic rsm_rel,
    input  logic main_good,
    input  logic pwr_ok,
    input  logic slow_tick,
    input  logic us_tick,
    input  logic wake,
    input  logic stop_grant,
    input  logic sleep_req,
    input  logic sleep_deep,
    output logic slp_shallow_n,
    output logic slp_deep_n,
    output logic susp_stat_n,
    output logic bus_rst_n,
    output logic cpu_slp_n,
    output logic stpclk_n
);
    localparam int MAX_CNT = (RST_US > CPU_CLKS) ? RST_US : CPU_CLKS;
    localparam int CW      = $clog2(MAX_CNT + 1);

    logic [NUM_DLY-1:0]         dly_start, dly_done, dly_tick;
    logic [NUM_DLY-1:0][CW-1:0] dly_target;
    logic                       entry_win, wake_take, wake_pend;

    assign dly_tick = {us_tick, 1'b1, slow_tick};

    for (genvar gi = 0; gi < NUM_DLY; gi++) begin : g_dly
        seq_delay #(.CW(CW)) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (!susp_good),
            .start  (dly_start[gi]),
            .target (dly_target[gi]),
            .tick   (dly_tick[gi]),
            .done   (dly_done[gi])
        );
    end

    seq_wake_hold u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (!susp_good),
        .wake       (wake),
        .capture_en (entry_win),
        .consume    (wake_take),
        .pending    (wake_pend)
    );

    seq_fsm #(
        .CW(CW), .RSM_TICKS(RSM_TICKS), .STAT_TICKS(STAT_TICKS),
        .BRST_TICKS(BRST_TICKS), .SHL_TICKS(SHL_TICKS), .DEEP_TICKS(DEEP_TICKS),
        .WAKE_TICKS(WAKE_TICKS), .CPU_CLKS(CPU_CLKS), .STP_CLKS(STP_CLKS),
        .RST_US(RST_US)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .susp_good     (susp_good),
        .rsm_rel       (rsm_rel),
        .main_good     (main_good),
        .pwr_ok        (pwr_ok),
        .wake_any      (wake || wake_pend),
        .sleep_req     (sleep_req),
        .sleep_deep    (sleep_deep),
        .stop_grant    (stop_grant),
        .dly_done      (dly_done),
        .dly_start     (dly_start),
        .dly_target    (dly_target),
        .entry_win     (entry_win),
        .wake_take     (wake_take),
        .slp_shallow_n (slp_shallow_n),
        .slp_deep_n    (slp_deep_n),
        .susp_stat_n   (susp_stat_n),
        .bus_rst_n     (bus_rst_n),
        .cpu_slp_n     (cpu_slp_n),
        .stpclk_n      (stpclk_n)
    );

endmodule

// File: tb/pwr_seq_ctrl_test.sv
// Directed bench for pwr_seq_ctrl. Output vector order used in checks:
// {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n}.
module pwr_seq_ctrl_test;
    localparam int RST_US = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic susp_good = 1'b0, rsm_rel = 1'b0, main_good = 1'b0, pwr_ok = 1'b0;
    logic slow_tick = 1'b0, us_tick = 1'b0, wake = 1'b0, stop_grant = 1'b0;
    logic sleep_req = 1'b0, sleep_deep = 1'b0;
    logic slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_ctrl #(.RST_US(RST_US)) uut (
        .clk(clk), .rst_n(rst_n), .susp_good(susp_good), .rsm_rel(rsm_rel),
        .main_good(main_good), .pwr_ok(pwr_ok), .slow_tick(slow_tick),
        .us_tick(us_tick), .wake(wake), .stop_grant(stop_grant),
        .sleep_req(sleep_req), .sleep_deep(sleep_deep),
        .slp_shallow_n(slp_shallow_n), .slp_deep_n(slp_deep_n),
        .susp_stat_n(susp_stat_n), .bus_rst_n(bus_rst_n),
        .cpu_slp_n(cpu_slp_n), .stpclk_n(stpclk_n)
    );

    function automatic logic [5:0] outs();
        return {slp_shallow_n, slp_deep_n, susp_stat_n, bus_rst_n, cpu_slp_n, stpclk_n};
    endfunction

    task automatic chk(input string tag, input logic [5:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", tag, outs(), exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_slow();
        @(negedge clk) slow_tick = 1'b1;
        @(negedge clk) slow_tick = 1'b0;
        cyc(18);
    endtask

    task automatic pulse_us();
        @(negedge clk) us_tick = 1'b1;
        @(negedge clk) us_tick = 1'b0;
        cyc(2);
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
    endtask

    // Reset state and resume-reset hold.
    task automatic t_reset();
        rst_n = 1'b0;
        cyc(4);
        chk("R1 reset", 6'b000000);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 rail low", 6'b000000);
        susp_good = 1'b1;
        cyc(3);
        chk("R1 resume held", 6'b000000);
    endtask

    // Main rail, power-OK, bus reset and stop-clock release.
    task automatic t_resume();
        main_good = 1'b1;
        cyc(2);
        chk("R3 cpu sleep release", 6'b111010);
        pwr_ok = 1'b1;
        cyc(2);
        for (int i = 1; i < RST_US; i++) pulse_us();
        chk("R4 bus reset before last us tick", 6'b111010);
        @(negedge clk) us_tick = 1'b1;
        @(negedge clk) us_tick = 1'b0;
        chk("R4 bus reset on last us tick", 6'b111110);
        cyc(1);
        chk("R5 stop clock after 1 clk", 6'b111110);
        cyc(1);
        chk("R5 stop clock after 2 clks", 6'b111111);
    endtask

    task automatic t_powerup();
        rsm_rel = 1'b1;
        cyc(3);
        pulse_slow();
        chk("R2 after 1st slow tick", 6'b000000);
        pulse_slow();
        chk("R2 after 2nd slow tick", 6'b111000);
        t_resume();
    endtask

    // Suspend entry; optional wake pulse injected mid-entry.
    task automatic t_enter(input logic deep, input logic mid_wake);
        @(negedge clk) begin sleep_req = 1'b1; sleep_deep = deep; end
        @(negedge clk) begin sleep_req = 1'b0; sleep_deep = 1'b0; end
        chk("R6 stop clock asserted", 6'b111110);
        main_good = 1'b0;
        pwr_ok = 1'b0;
        cyc(3);
        chk("R6 waits for grant", 6'b111110);
        @(negedge clk) stop_grant = 1'b1;
        @(negedge clk) stop_grant = 1'b0;
        cyc(7);
        chk("R6 cpu sleep not before 8 clks", 6'b111110);
        cyc(1);
        chk("R6 cpu sleep at 8 clks", 6'b111100);
        if (mid_wake) pulse_wake();
        pulse_slow();
        chk("R7 status after 1 tick", 6'b110100);
        pulse_slow();
        pulse_slow();
        chk("R8 bus reset held 2 ticks", 6'b110100);
        pulse_slow();
        chk("R8 bus reset at 3rd tick", 6'b110000);
        pulse_slow();
        chk("R8 shallow held 1 tick", 6'b110000);
        pulse_slow();
        chk("R8 shallow at 2nd tick", 6'b010000);
        if (deep) begin
            pulse_slow();
            chk("R9 deep held 1 tick", 6'b010000);
            pulse_slow();
            chk("R9 deep at 2nd tick", 6'b000000);
        end else begin
            pulse_slow();
            pulse_slow();
            chk("R9 deep stays high for shallow", 6'b010000);
        end
    endtask

    task automatic t_wake(input logic deep);
        pulse_wake();
        if (deep) begin
            pulse_slow();
            pulse_slow();
            chk("R10 deep held 2 ticks", 6'b000000);
            pulse_slow();
            chk("R10 deep released first", 6'b010000);
        end
        pulse_slow();
        pulse_slow();
        chk("R10 shallow held 2 ticks", 6'b010000);
        pulse_slow();
        chk("R10 shallow and status released", 6'b111000);
        t_resume();
    endtask

    // Wake while running is dropped; later sleep stays asleep.
    task automatic t_ignored_wake();
        pulse_wake();
        cyc(3);
        chk("R11 wake while on ignored", 6'b111111);
        t_enter(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) pulse_slow();
        chk("R11 stays asleep without wake", 6'b010000);
    endtask

    // Wake during entry is held and taken after the strobes settle.
    task automatic t_pending_wake();
        t_enter(1'b0, 1'b1);
        pulse_slow();
        chk("R11 held wake releases shallow", 6'b111000);
        t_resume();
    endtask

    task automatic t_rail_drop();
        @(negedge clk) susp_good = 1'b0;
        cyc(1);
        chk("R1 rail drop all asserted", 6'b000000);
        cyc(3);
        chk("R1 rail drop held", 6'b000000);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_ignored_wake();
        t_wake(1'b0);
        t_enter(1'b1, 1'b0);
        t_wake(1'b1);
        t_pending_wake();
        t_rail_drop();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, outputs %b expected completion", outs());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule